// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of trace words into on-chip storage that it treats as a ring. Once software enables capture, every word presented with a valid strobe is stored and the write position moves forward, wrapping at the end of the storage. After a trigger pulse arrives, a post-trigger counter decides how many more words are kept. When that counter runs out, recording halts, so the storage holds a window of history around the trigger event.

A host reaches the block through a simple register port. Each read strobe returns its data on the following cycle. Through this port the host programs the post-trigger count and the starting write position, starts and stops capture, and polls status. To unload the buffer it uses the wrap flag to find the oldest entry, sets the read position there, and reads the data register repeatedly. Every such read steps the read position forward by one. Storage depth and word width are parameters, and the host can read both back.

Top module: `trace_capture_buf`

## Requirements
- R1: Register addresses are 0 identification (reads ID_VALUE), 1 depth (reads DEPTH), 2 width (reads WIDTH), 3 status, 4 data, 5 read pointer, 6 write pointer, 7 post-trigger count, 8 control. A read strobe returns its value on reg_rdata_o one cycle later. After reset: status reads 0x8, control reads 0, both pointers read 0.
- R2: While control bit 0 (enable) is 1, each cycle with trc_valid_i high stores trc_data_i at the write pointer. The write pointer then advances, wrapping from DEPTH-1 to 0. While enable is 0, words are dropped.
- R3: Status bit 0 (full) sets when a store wraps the write pointer from DEPTH-1 to 0. From then on, the oldest valid entry is at the write pointer. While full is 0, the valid entries are 0 up to the write pointer minus one.
- R4: Status bit 1 (triggered) sets when trig_i is high while enable is 1. trig_i has no effect while enable is 0.
- R5: Each word stored in a cycle after the trigger was seen decrements the post-trigger count. In any cycle where triggered is 1 and the count is 0, status bit 2 (done) sets, the word in that cycle is not stored, and control bit 0 clears. The word that arrives with the trigger is stored and does not count.
- R6: Status bit 3 (drained) is 0 while capture has been enabled for more than one cycle. It rises DRAIN cycles after capture ends.
- R7: A read of the data register returns the entry at the read pointer. The read pointer then advances modulo DEPTH. Writes to address 5 set the read pointer.
- R8: Writes to the write pointer and to the post-trigger count take effect only while enable is 0.
- R9: A control write that sets enable while it is 0 clears status bits 0, 1 and 2.
- R10: Control bit 1 (demultiplexed mode) reads back as written when PORT_BITS is 8, and reads 0 otherwise.
- R11: Writing 0 to the control register stops storage at once and leaves the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trc_data_i | input | WIDTH | Trace word |
| trc_valid_i | input | 1 | Trace word valid |
| trig_i | input | 1 | Trigger event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one cycle after reg_rd_i |

## Verification
The hardest situation to reach is the one where the trigger lands late enough that the post-trigger words push the write pointer past the end of the ring. In that case the full flag, the stop point and the oldest-entry position all interact. The stimulus gets there by choosing, with a fixed-seed $urandom, the trigger position and the post-trigger percentage so that the total stored count sometimes exceeds DEPTH and sometimes does not. Random idle gaps in the word stream show that the count follows stored words rather than cycles. Directed runs add the extremes: a zero count that stops capture right after the trigger cycle, and a wrap scenario in which the drained flag is sampled before and after the drain delay.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [3:0] {
    A_IDENT  = 4'd0,
    A_DEPTH  = 4'd1,
    A_WIDTH  = 4'd2,
    A_STATUS = 4'd3,
    A_DATA   = 4'd4,
    A_RDPTR  = 4'd5,
    A_WRPTR  = 4'd6,
    A_TRGCNT = 4'd7,
    A_CTRL   = 4'd8
  } reg_addr_e;

  localparam int ST_FULL  = 0;
  localparam int ST_TRIG  = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_DRAIN = 3;
  localparam int CT_EN    = 0;
  localparam int CT_DEMUX = 1;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture #(
  parameter int DEPTH = 64,
  parameter int DRAIN = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = $clog2(DRAIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trc_valid_i,
  input  logic          trig_i,
  input  logic          ctl_wr_i,
  input  logic          ctl_en_i,
  input  logic          wp_wr_i,
  input  logic [AW-1:0] wp_val_i,
  input  logic          tc_wr_i,
  input  logic [CW-1:0] tc_val_i,
  output logic          en_o,
  output logic          full_o,
  output logic          trig_o,
  output logic          done_o,
  output logic          drained_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic          we_o
);
  logic          en_q, full_q, trig_q, done_q;
  logic [AW-1:0] wp_q, wp_nxt;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] drain_q;
  logic          en_rise, stop_now, store;

  assign en_rise  = ctl_wr_i && ctl_en_i && !en_q;
  assign stop_now = en_q && trig_q && (cnt_q == '0);
  assign store    = en_q && !stop_now && trc_valid_i;
  assign wp_nxt   = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      full_q  <= 1'b0;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
      wp_q    <= '0;
      cnt_q   <= '0;
      drain_q <= '0;
    end else begin
      // completion outranks a concurrent control write
      if (stop_now)      en_q <= 1'b0;
      else if (ctl_wr_i) en_q <= ctl_en_i;

      if (en_rise) begin
        full_q <= 1'b0;
        trig_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (store && wp_q == AW'(DEPTH - 1)) full_q <= 1'b1;
        if (en_q && trig_i)                  trig_q <= 1'b1;
        if (stop_now)                        done_q <= 1'b1;
      end

      if (wp_wr_i && !en_q) wp_q <= wp_val_i;
      else if (store)       wp_q <= wp_nxt;

      if (tc_wr_i && !en_q)                        cnt_q <= tc_val_i;
      else if (store && trig_q && cnt_q != '0)     cnt_q <= cnt_q - CW'(1);

      if (en_q)                drain_q <= DW'(DRAIN);
      else if (drain_q != '0)  drain_q <= drain_q - DW'(1);
    end
  end

  assign en_o      = en_q;
  assign full_o    = full_q;
  assign trig_o    = trig_q;
  assign done_o    = done_q;
  assign drained_o = (drain_q == '0);
  assign wr_ptr_o  = wp_q;
  assign cnt_o     = cnt_q;
  assign we_o      = store;
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int          DEPTH     = 64,
  parameter int          WIDTH     = 24,
  parameter int          PORT_BITS = 8,
  parameter int          DRAIN     = 4,
  parameter logic [31:0] ID_VALUE  = 32'h5A17_0C01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] trc_data_i,
  input  logic             trc_valid_i,
  input  logic             trig_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  reg_addr_e      addr;
  logic           cap_en, cap_full, cap_trig, cap_done, cap_drained, ram_we;
  logic [AW-1:0]  wr_ptr, rd_ptr_q, rd_ptr_nxt;
  logic [CW-1:0]  trg_cnt;
  logic [WIDTH-1:0] ram_q;
  logic           demux;
  logic           data_rd, sel_data_q;
  logic [31:0]    rdata_q, rd_mux;
  logic           unused_wdata;

  assign addr    = reg_addr_e'(reg_addr_i);
  assign data_rd = reg_rd_i && (addr == A_DATA);
  assign unused_wdata = ^reg_wdata_i;

  tcb_capture #(.DEPTH(DEPTH), .DRAIN(DRAIN)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trc_valid_i(trc_valid_i),
    .trig_i     (trig_i),
    .ctl_wr_i   (reg_wr_i && addr == A_CTRL),
    .ctl_en_i   (reg_wdata_i[CT_EN]),
    .wp_wr_i    (reg_wr_i && addr == A_WRPTR),
    .wp_val_i   (reg_wdata_i[AW-1:0]),
    .tc_wr_i    (reg_wr_i && addr == A_TRGCNT),
    .tc_val_i   (reg_wdata_i[CW-1:0]),
    .en_o       (cap_en),
    .full_o     (cap_full),
    .trig_o     (cap_trig),
    .done_o     (cap_done),
    .drained_o  (cap_drained),
    .wr_ptr_o   (wr_ptr),
    .cnt_o      (trg_cnt),
    .we_o       (ram_we)
  );

  tcb_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk_i    (clk_i),
    .wr_en_i  (ram_we),
    .wr_addr_i(wr_ptr),
    .wr_data_i(trc_data_i),
    .rd_en_i  (data_rd),
    .rd_addr_i(rd_ptr_q),
    .rd_data_o(ram_q)
  );

  generate
    if (PORT_BITS == 8) begin : g_demux
      logic demux_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          demux_q <= 1'b0;
        else if (reg_wr_i && addr == A_CTRL)  demux_q <= reg_wdata_i[CT_DEMUX];
      end
      assign demux = demux_q;
    end else begin : g_nodemux
      assign demux = 1'b0;
    end
  endgenerate

  assign rd_ptr_nxt = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rd_ptr_q <= '0;
    else if (reg_wr_i && addr == A_RDPTR) rd_ptr_q <= reg_wdata_i[AW-1:0];
    else if (data_rd)                     rd_ptr_q <= rd_ptr_nxt;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_IDENT:  rd_mux = ID_VALUE;
      A_DEPTH:  rd_mux = 32'(DEPTH);
      A_WIDTH:  rd_mux = 32'(WIDTH);
      A_STATUS: rd_mux = {28'd0, cap_drained, cap_done, cap_trig, cap_full};
      A_RDPTR:  rd_mux = 32'(rd_ptr_q);
      A_WRPTR:  rd_mux = 32'(wr_ptr);
      A_TRGCNT: rd_mux = 32'(trg_cnt);
      A_CTRL:   rd_mux = {30'd0, demux, cap_en};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      sel_data_q <= 1'b0;
    end else if (reg_rd_i) begin
      rdata_q    <= rd_mux;
      sel_data_q <= data_rd;
    end
  end

  assign reg_rdata_o = sel_data_q ? 32'(ram_q) : rdata_q;
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_rd_i,
  input logic          reg_wr_i,
  input logic [3:0]    reg_addr_i,
  input logic          en,
  input logic          full,
  input logic          done,
  input logic          drained,
  input logic          we,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr
);
  AST_WRPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> wr_ptr == (($past(wr_ptr) == AW'(DEPTH - 1)) ? '0 : $past(wr_ptr) + AW'(1))); // R2

  AST_FULL_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && wr_ptr == AW'(DEPTH - 1)) |=> full); // R3

  AST_DONE_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !we); // R5

  AST_DONE_DROPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> !en); // R5

  AST_DRAIN_LOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en)) |-> !drained); // R6

  AST_RDPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !reg_wr_i && reg_addr_i == 4'd4) |=>
      rd_ptr == (($past(rd_ptr) == AW'(DEPTH - 1)) ? '0 : $past(rd_ptr) + AW'(1))); // R7

  AST_WRPTR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !we) |=> $stable(wr_ptr)); // R8
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_rd_i  (reg_rd_i),
  .reg_wr_i  (reg_wr_i),
  .reg_addr_i(reg_addr_i),
  .en        (cap_en),
  .full      (cap_full),
  .done      (cap_done),
  .drained   (cap_drained),
  .we        (ram_we),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr_q)
);

// File: tb/sim_trace_capture_buf.sv
module sim_trace_capture_buf;
  localparam int DEPTH = 16;
  localparam int WIDTH = 24;
  localparam int DRAIN = 4;
  localparam logic [31:0] IDV = 32'h5A17_0C01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WIDTH-1:0] trc_data = '0;
  logic trc_valid = 1'b0, trig = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int total = 0, fails = 0;
  logic [31:0] words [64];
  logic [31:0] v;

  always #5 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PORT_BITS(8), .DRAIN(DRAIN), .ID_VALUE(IDV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trc_data_i(trc_data), .trc_valid_i(trc_valid),
    .trig_i(trig), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata));

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(logic [31:0] d, logic vld, logic t);
    trc_data = d[WIDTH-1:0]; trc_valid = vld; trig = t;
    @(negedge clk);
    trc_valid = 1'b0; trig = 1'b0;
  endtask

  function automatic int post_count(int pct);
    return (DEPTH * pct) / 100;
  endfunction

  function automatic int stored_total(int tpos, int cnt);
    return tpos + 1 + cnt;
  endfunction

  function automatic logic [31:0] rnd_word();
    return $urandom & 32'h00FF_FFFF;
  endfunction

  // read back the ring after a capture of n words and compare
  task automatic drain_check(string req, int n);
    bit wrapped = (n >= DEPTH);
    int first = wrapped ? n - DEPTH : 0;
    int cnt   = wrapped ? DEPTH : n;
    rd(6, v); chk(req, v, 32'(n % DEPTH));
    rd(3, v); chk(req, {31'd0, v[0]}, {31'd0, wrapped});
    wr(5, 32'(n % DEPTH * int'(wrapped)));
    for (int i = 0; i < cnt; i++) begin
      rd(4, v); chk(req, v, words[first + i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset and identity
    rd(0, v); chk("R1 ident", v, IDV);
    rd(1, v); chk("R1 depth", v, DEPTH);
    rd(2, v); chk("R1 width", v, WIDTH);
    rd(3, v); chk("R1 status", v, 32'h8);
    rd(8, v); chk("R1 ctrl", v, 32'h0);
    rd(5, v); chk("R1 rdptr", v, 32'h0);
    rd(6, v); chk("R1 wrptr", v, 32'h0);

    // R2 R4 disabled: words dropped, trigger ignored
    for (int i = 0; i < 3; i++) push(rnd_word(), 1'b1, 1'b1);
    rd(6, v); chk("R2 drop while disabled", v, 0);
    rd(3, v); chk("R4 trigger ignored", v, 32'h8);

    // R10 mode bit
    wr(8, 32'h2);
    rd(8, v); chk("R10 demux readback", v, 32'h2);
    wr(8, 32'h0);

    // R7 R8 R11 plain run, no trigger
    wr(7, 5); wr(6, 0); wr(8, 1);
    for (int i = 0; i < 5; i++) begin
      words[i] = rnd_word();
      push(words[i], 1'b1, 1'b0);
    end
    wr(6, 9);
    rd(6, v); chk("R8 wrptr locked", v, 5);
    wr(7, 1);
    rd(7, v); chk("R8 count locked", v, 5);
    wr(8, 0);
    push(rnd_word(), 1'b1, 1'b0);
    push(rnd_word(), 1'b1, 1'b1);
    rd(6, v); chk("R11 stop halts store", v, 5);
    repeat (DRAIN) @(negedge clk);
    rd(3, v); chk("R11 flags kept", v, 32'h8);
    wr(5, 0);
    for (int i = 0; i < 5; i++) begin
      rd(4, v); chk("R7 data read", v, words[i]);
    end
    rd(5, v); chk("R7 rdptr advanced", v, 5);

    // R3 R5 R6 directed wrap: trigger on word 11, 8 more words
    wr(7, post_count(50)); wr(6, 0); wr(8, 1);
    for (int i = 0; i < 20; i++) begin
      words[i] = rnd_word();
      push(words[i], 1'b1, i == 11);
    end
    push(rnd_word(), 1'b1, 1'b0);
    rd(3, v); chk("R6 not drained yet", v, 32'h7);
    rd(8, v); chk("R5 enable cleared", v, 32'h0);
    repeat (DRAIN + 2) @(negedge clk);
    rd(3, v); chk("R6 drained", v, 32'hF);
    push(rnd_word(), 1'b1, 1'b0);
    drain_check("R3 wrap readback", stored_total(11, post_count(50)));

    // R5 R9 zero count stops right after trigger
    wr(7, 0); wr(6, 0); wr(8, 1);
    rd(3, v); chk("R9 flags cleared", v & 32'h7, 32'h0);
    for (int i = 0; i < 3; i++) push(rnd_word(), 1'b1, i == 2);
    push(rnd_word(), 1'b1, 1'b0);
    push(rnd_word(), 1'b1, 1'b0);
    rd(6, v); chk("R5 zero count stop", v, 3);
    repeat (DRAIN + 2) @(negedge clk);
    rd(3, v); chk("R5 done status", v, 32'hE);

    // R2 R3 R5 R7 random rounds with gaps
    for (int r = 0; r < 8; r++) begin
      int pct  = 2 + int'($urandom % 99);
      int tpos = int'($urandom % 31);
      int c    = post_count(pct);
      int n    = stored_total(tpos, c);
      wr(7, c); wr(6, 0); wr(8, 1);
      for (int i = 0; i < n + 3; i++) begin
        if ($urandom % 4 == 0) @(negedge clk);
        words[i] = rnd_word();
        push(words[i], 1'b1, i == tpos);
      end
      repeat (DRAIN + 2) @(negedge clk);
      rd(3, v); chk("R5 random done", v[2:0] & 32'h6, 32'h6);
      drain_check("R2 random readback", n);
    end

    summary();
    $finish;
  end
endmodule